// File: doc/BRIEF.md
# Dual-Port Cache Tag Readout Unit

This block keeps the address tags of a set-associative data cache and answers a diagnostic tag-read request on each of two issue ports. A request carries a 32-bit base value, a signed displacement, a guard word and a valid strobe. The unit adds the base and the displacement to form a block address. It picks a set and an element from fixed fields of that address. It returns the stored tag zero-extended to 32 bits, together with a destination write-enable that follows bit 0 of the guard.

Each issue port reads a private duplicate of the tag array, so the two ports never compete for a read path. A single fill port writes the same entry into both duplicates in one cycle. Responses are registered and arrive one clock after the request, with no stall. A displacement that is not allowed is flagged, and the write-enable is withheld for that request.

Top module: `tagrd_dual_port`

## Requirements
- R1: The block address is `req_base + sign_extend(req_disp)` (12-bit two's-complement displacement); address bits [10:6] select the set (0..31) and bits [13:11] select the element (0..7).
- R2: `rsp_result` bits [21:0] hold the tag stored at the selected set and element, and bits [31:22] are zero.
- R3: A request with `req_valid` high on a port yields `rsp_valid` high on that port exactly one clock later; a cycle without a request yields `rsp_valid` low one clock later.
- R4: `rsp_wen` is 1 only for a valid, error-free request whose guard bit 0 is 1; it is 0 when guard bit 0 is 0, whatever the other guard bits hold.
- R5: `rsp_err` is 1 when the displacement is below -256, above 252, or not a multiple of 4 (bits [1:0] non-zero); `rsp_wen` is then 0 and `rsp_result` still carries the tag at the computed address.
- R6: A fill (`fill_en` with set, element and 22-bit tag) updates the tag copies of both ports, so a later read of that entry on either port returns the new tag.
- R7: A read of an entry in the same cycle as a fill of that entry returns the previous tag; a read in the following cycle returns the new one.
- R8: Synchronous active-low reset clears every tag in both copies to zero and drives all response outputs to zero.
- R9: Both ports accept requests in the same cycle and answer each independently, each from its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 2 | Request strobe per port |
| req_base | input | 2x32 | Base operand per port |
| req_disp | input | 2x12 | Signed displacement per port |
| req_guard | input | 2x32 | Guard operand per port, bit 0 used |
| fill_en | input | 1 | Tag fill strobe |
| fill_set | input | 5 | Set written by a fill |
| fill_elem | input | 3 | Element written by a fill |
| fill_tag | input | 22 | Tag value written by a fill |
| rsp_valid | output | 2 | Response valid per port |
| rsp_result | output | 2x32 | Zero-extended tag per port |
| rsp_wen | output | 2 | Destination write-enable per port |
| rsp_err | output | 2 | Displacement error per port |

## Verification
The two functions that can meet in one cycle are a tag fill and a tag read of the very same entry, and beyond that the two ports reading at once. The bench provokes the first by driving a fill and a read on both ports to one set and element on the same clock, and judges it against a model that is only updated after the expectation is queued, so the old tag is required; the next read must show the new tag on both ports. Simultaneous requests on both ports with different addresses are queued per port and compared in order.

// File: rtl/tagrd_pkg.sv
// Package: shared word type and fixed architectural widths for the tag
// readout unit. Assumes a 32-bit operand datapath.
package tagrd_pkg;
    localparam int unsigned TAGRD_WORD_W = 32;
    typedef logic [TAGRD_WORD_W-1:0] tagrd_word_t;
endpackage

// File: rtl/tagrd_addr_gen.sv
// Address generator: adds base and sign-extended displacement, slices out
// the set and element indices and checks the displacement for range and
// alignment. Purely combinational; assumes DISP_W < DATA_W.
module tagrd_addr_gen #(
    parameter int DATA_W     = 32,
    parameter int DISP_W     = 12,
    parameter int SET_LSB    = 6,
    parameter int SET_W      = 5,
    parameter int ELEM_W     = 3,
    parameter int DISP_MIN   = -256,
    parameter int DISP_MAX   = 252,
    parameter int ALIGN_BITS = 2
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [SET_W-1:0]  set_o,
    output logic [ELEM_W-1:0] elem_o,
    output logic              err_o
);
    localparam int ELEM_LSB = SET_LSB + SET_W;

    logic [DATA_W-1:0] disp_ext;
    logic [DATA_W-1:0] blk_addr;
    logic              below_min;
    logic              above_max;
    logic              misaligned;

    // Form the block address and slice out the indices.
    always_comb begin
        disp_ext = {{(DATA_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
        blk_addr = base_i + disp_ext;
        set_o    = blk_addr[SET_LSB +: SET_W];
        elem_o   = blk_addr[ELEM_LSB +: ELEM_W];
    end

    // Judge the displacement against the allowed window and step.
    always_comb begin
        below_min  = $signed(disp_i) < DISP_MIN;
        above_max  = $signed(disp_i) > DISP_MAX;
        misaligned = disp_i[ALIGN_BITS-1:0] != '0;
        err_o      = below_min | above_max | misaligned;
    end
endmodule

// File: rtl/tagrd_tag_bank.sv
// Tag bank: one full copy of the tag array with a single write (fill) port
// and a combinational read port. A read in the cycle of a write to the same
// entry sees the old content, since the write lands at the clock edge.
module tagrd_tag_bank #(
    parameter int TAG_W  = 22,
    parameter int SET_W  = 5,
    parameter int ELEM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [ELEM_W-1:0] fill_elem,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [ELEM_W-1:0] rd_elem,
    output logic [TAG_W-1:0]  rd_tag
);
    localparam int IDX_W = SET_W + ELEM_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_idx = {fill_elem, fill_set};
    assign rd_idx = {rd_elem, rd_set};

    // Clear every entry on reset, otherwise apply a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (fill_en) begin
            mem[wr_idx] <= fill_tag;
        end
    end

    // Read the addressed entry.
    assign rd_tag = mem[rd_idx];

    // R6
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> mem[$past(wr_idx)] == $past(fill_tag));
endmodule

// File: rtl/tagrd_resp_reg.sv
// Response register: captures the tag, the guard-driven write-enable and
// the error flag one clock after a request. Assumes TAG_W < DATA_W.
module tagrd_resp_reg #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              guard_lsb,
    input  logic              disp_err,
    input  logic [TAG_W-1:0]  tag_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_result,
    output logic              rsp_wen,
    output logic              rsp_err
);
    // Register the response; results hold between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_result <= '0;
            rsp_wen    <= 1'b0;
            rsp_err    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_wen   <= req_valid & guard_lsb & ~disp_err;
            rsp_err   <= req_valid & disp_err;
            if (req_valid) begin
                rsp_result <= {{(DATA_W-TAG_W){1'b0}}, tag_in};
            end
        end
    end

    // R3
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R3
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R4
    wen_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !guard_lsb) |=> !rsp_wen);
    // R5
    err_blocks_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_wen);
endmodule

// File: rtl/tagrd_dual_port.sv
// Top: two issue ports, each with its own address generator, its own copy
// of the tag array and its own response register. The fill port writes all
// copies together. Assumes SET_LSB + SET_W + ELEM_W <= DATA_W.
module tagrd_dual_port #(
    parameter int NPORT      = 2,
    parameter int DATA_W     = tagrd_pkg::TAGRD_WORD_W,
    parameter int DISP_W     = 12,
    parameter int TAG_W      = 22,
    parameter int SET_LSB    = 6,
    parameter int SET_W      = 5,
    parameter int ELEM_W     = 3,
    parameter int DISP_MIN   = -256,
    parameter int DISP_MAX   = 252,
    parameter int ALIGN_BITS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              req_valid,
    input  logic [NPORT-1:0][DATA_W-1:0]  req_base,
    input  logic [NPORT-1:0][DISP_W-1:0]  req_disp,
    input  logic [NPORT-1:0][DATA_W-1:0]  req_guard,
    input  logic                          fill_en,
    input  logic [SET_W-1:0]              fill_set,
    input  logic [ELEM_W-1:0]             fill_elem,
    input  logic [TAG_W-1:0]              fill_tag,
    output logic [NPORT-1:0]              rsp_valid,
    output logic [NPORT-1:0][DATA_W-1:0]  rsp_result,
    output logic [NPORT-1:0]              rsp_wen,
    output logic [NPORT-1:0]              rsp_err
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [SET_W-1:0]  set_idx;
        logic [ELEM_W-1:0] elem_idx;
        logic              disp_err;
        logic [TAG_W-1:0]  tag_rd;

        tagrd_addr_gen #(
            .DATA_W(DATA_W), .DISP_W(DISP_W), .SET_LSB(SET_LSB),
            .SET_W(SET_W), .ELEM_W(ELEM_W), .DISP_MIN(DISP_MIN),
            .DISP_MAX(DISP_MAX), .ALIGN_BITS(ALIGN_BITS)
        ) u_agen (
            .base_i (req_base[p]),
            .disp_i (req_disp[p]),
            .set_o  (set_idx),
            .elem_o (elem_idx),
            .err_o  (disp_err)
        );

        tagrd_tag_bank #(
            .TAG_W(TAG_W), .SET_W(SET_W), .ELEM_W(ELEM_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill_en   (fill_en),
            .fill_set  (fill_set),
            .fill_elem (fill_elem),
            .fill_tag  (fill_tag),
            .rd_set    (set_idx),
            .rd_elem   (elem_idx),
            .rd_tag    (tag_rd)
        );

        tagrd_resp_reg #(
            .DATA_W(DATA_W), .TAG_W(TAG_W)
        ) u_resp (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid[p]),
            .guard_lsb  (req_guard[p][0]),
            .disp_err   (disp_err),
            .tag_in     (tag_rd),
            .rsp_valid  (rsp_valid[p]),
            .rsp_result (rsp_result[p]),
            .rsp_wen    (rsp_wen[p]),
            .rsp_err    (rsp_err[p])
        );

        // R5
        misalign_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && req_disp[p][ALIGN_BITS-1:0] != '0) |=> rsp_err[p]);
        // R2
        upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[p] |-> rsp_result[p][DATA_W-1:TAG_W] == '0);
    end
endmodule

// File: tb/tagrd_dual_port_tb.sv
// Scoreboard bench: driver tasks queue expected responses per port from an
// independent tag model; a monitor pops and compares at the falling edge.
module tagrd_dual_port_tb;
    typedef struct {
        logic [31:0] res;
        logic        wen;
        logic        err;
        string       tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           req_valid = '0;
    logic [1:0][31:0]     req_base = '0;
    logic [1:0][11:0]     req_disp = '0;
    logic [1:0][31:0]     req_guard = '0;
    logic                 fill_en = 1'b0;
    logic [4:0]           fill_set = '0;
    logic [2:0]           fill_elem = '0;
    logic [21:0]          fill_tag = '0;
    logic [1:0]           rsp_valid;
    logic [1:0][31:0]     rsp_result;
    logic [1:0]           rsp_wen;
    logic [1:0]           rsp_err;

    logic [21:0] model [8][32];
    exp_t        q0[$];
    exp_t        q1[$];
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    tagrd_dual_port u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_disp(req_disp), .req_guard(req_guard), .fill_en(fill_en),
        .fill_set(fill_set), .fill_elem(fill_elem), .fill_tag(fill_tag),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_wen(rsp_wen),
        .rsp_err(rsp_err)
    );

    function automatic logic [21:0] pattern(int e, int s);
        return 22'((e * 32 + s + 1) * 13577) ^ 22'h2A5A5;
    endfunction

    task automatic req(int p, logic [31:0] base, logic [11:0] disp,
                       logic [31:0] guard, string tag);
        exp_t        e;
        logic [31:0] a;
        a     = base + {{20{disp[11]}}, disp};
        e.err = ($signed(disp) < -256) || ($signed(disp) > 252) || (disp[1:0] != 2'b00);
        e.res = {10'b0, model[a[13:11]][a[10:6]]};
        e.wen = guard[0] && !e.err;
        e.tag = tag;
        req_valid[p] = 1'b1;
        req_base[p]  = base;
        req_disp[p]  = disp;
        req_guard[p] = guard;
        if (p == 0) q0.push_back(e); else q1.push_back(e);
    endtask

    task automatic fill(int e, int s, logic [21:0] t);
        fill_en   = 1'b1;
        fill_elem = 3'(e);
        fill_set  = 5'(s);
        fill_tag  = t;
    endtask

    task automatic commit();
        @(posedge clk);
        if (fill_en) model[fill_elem][fill_set] = fill_tag;
        #1;
        req_valid = '0;
        fill_en   = 1'b0;
    endtask

    function automatic logic [31:0] base_for(int e, int s, logic [11:0] disp, int hi);
        logic [31:0] target;
        target = (32'(hi) << 14) | (32'(e) << 11) | (32'(s) << 6) | 32'(hi & 63);
        return target - {{20{disp[11]}}, disp};
    endfunction

    task automatic compare(int p, exp_t e);
        checks++;
        if (rsp_result[p] !== e.res) begin
            fails++;
            $display("FAIL %s R1 R2 port%0d result actual %h expected %h", e.tag, p, rsp_result[p], e.res);
        end else if (rsp_wen[p] !== e.wen) begin
            fails++;
            $display("FAIL %s R4 port%0d wen actual %b expected %b", e.tag, p, rsp_wen[p], e.wen);
        end else if (rsp_err[p] !== e.err) begin
            fails++;
            $display("FAIL %s R5 port%0d err actual %b expected %b", e.tag, p, rsp_err[p], e.err);
        end
    endtask

    // Monitor: pop and compare every response.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                if (rsp_valid[p]) begin
                    if ((p == 0 ? q0.size() : q1.size()) == 0) begin
                        checks++;
                        fails++;
                        $display("FAIL R3 port%0d unexpected response actual valid 1 expected 0", p);
                    end else if (p == 0) begin
                        compare(0, q0.pop_front());
                    end else begin
                        compare(1, q1.pop_front());
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R3 watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        for (int e = 0; e < 8; e++)
            for (int s = 0; s < 32; s++) model[e][s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 2'b00 || rsp_result !== '0 || rsp_wen !== 2'b00 || rsp_err !== 2'b00) begin
            fails++;
            $display("FAIL R8 reset outputs actual %b/%h expected 0/0", rsp_valid, rsp_result);
        end
        @(posedge clk); #1 rst_n = 1'b1;

        // R8: tags read as zero after reset, on both ports
        req(0, base_for(3, 7, 12'd0, 1), 12'd0, 32'd1, "R8");
        req(1, base_for(7, 31, 12'd4, 2), 12'd4, 32'd1, "R8");
        commit();

        // R6: fill all entries
        for (int e = 0; e < 8; e++)
            for (int s = 0; s < 32; s++) begin
                fill(e, s, pattern(e, s));
                commit();
            end

        // R1 R4 R9: reads on both ports, varied displacement and guard
        for (int i = 0; i < 48; i++) begin
            for (int p = 0; p < 2; p++) begin
                int          e;
                int          s;
                logic [11:0] d;
                e = (i * 3 + p * 5) % 8;
                s = (i * 7 + p * 11) % 32;
                d = 12'(-256 + ((i * 13 + p * 29) % 128) * 4);
                req(p, base_for(e, s, d, i + p), d, 32'(i + p * 2), p == 0 ? "R1" : "R9");
            end
            commit();
        end
        // R4: guard bit 0 clear with other bits set
        req(0, base_for(1, 2, 12'd252, 5), 12'd252, 32'hFFFF_FFFE, "R4");
        req(1, base_for(6, 30, 12'hF00, 9), 12'hF00, 32'h0000_0003, "R4");
        commit();

        // R5: illegal displacements
        req(0, 32'h0000_4000, 12'd256, 32'd1, "R5");
        req(1, 32'h0000_4000, 12'hEFC, 32'd1, "R5");
        commit();
        req(0, 32'h0000_2040, 12'd6, 32'd1, "R5");
        req(1, 32'h0000_2040, 12'h7FF, 32'd1, "R5");
        commit();
        req(0, 32'h0001_0000, 12'h800, 32'd1, "R5");
        req(1, 32'h0000_0800, 12'hEFF, 32'd1, "R5");
        commit();

        // R7: fill and read the same entry in one cycle, then read again
        req(0, base_for(2, 9, 12'd0, 3), 12'd0, 32'd1, "R7");
        req(1, base_for(2, 9, 12'd8, 4), 12'd8, 32'd1, "R7");
        fill(2, 9, 22'h3C0FF3);
        commit();
        req(0, base_for(2, 9, 12'd0, 3), 12'd0, 32'd1, "R7");
        req(1, base_for(2, 9, 12'hFF0, 4), 12'hFF0, 32'd1, "R6");
        commit();

        // R3: idle cycle gives no response
        commit();
        @(negedge clk);
        checks++;
        if (rsp_valid !== 2'b00) begin
            fails++;
            $display("FAIL R3 idle cycle valid actual %b expected 00", rsp_valid);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (q0.size() != 0 || q1.size() != 0) begin
            fails++;
            $display("FAIL R3 missing responses actual %0d/%0d pending expected 0/0", q0.size(), q1.size());
        end
        finish_run();
    end
endmodule